// File: doc/BRIEF.md
# Fixed-Address Bus Slave I/O Port

This block lets a logic design act as one I/O port on an S-100 style backplane. It watches the sixteen address lines, the output and input status signals, and the write and read strobes. When the processor writes to the port's address, the block captures the byte from the data-out lines and shows it on eight indicator outputs. When the processor reads that address, the block places a byte on the data-in lines. A parameter selects the byte that a read returns. It is either the last byte written, or a 4-bit switch value that appears in both halves of the byte.

Every bus input passes through a synchroniser into the system clock domain before any decode. A write is captured once, on the cycle in which the qualified write condition first becomes true. The block also produces the active-low output enable and the direction control for the external bus transceivers. It asserts them only while a matching read is in progress. An active-low activity flag pulses for one cycle at the start of each access. A mode input selects slave or master operation, and the block responds only in slave mode.

Top module: `s100_port_slave`

## Requirements
- R1: A write is recognised when sOUT is high, the active-low write strobe is low and the 16-bit address equals PORT_ADDR (default 16'h0068). The data-out byte then appears on `led` after the third rising clock edge that follows the inputs.
- R2: A write to any address that differs from PORT_ADDR in any bit, such as 16'h0069, 16'h0168 or 16'h8068, leaves `led` unchanged.
- R3: If the write strobe is low while sOUT is low, or sOUT is high while the write strobe is high, `led` is unchanged.
- R4: After reset, `led` is 8'h00, `xcvr_oe_n` is 1, `xcvr_to_bus` is 0, `bus_din` is 8'h00 and `active_n` is 1.
- R5: With READBACK=1, a read of PORT_ADDR (sINP high, pDBIN high) returns the byte last written to the port on `bus_din`.
- R6: With READBACK=0, a read of PORT_ADDR returns {sw, sw}, with the switch value in bits 7:4 and in bits 3:0.
- R7: `xcvr_oe_n` is low only while the synchronised read condition holds. This is from the second rising edge after the read begins until the second rising edge after it ends. Whenever `xcvr_oe_n` is high, `bus_din` is 8'h00.
- R8: While `dir_master` is high (master mode), writes do not change `led` and reads do not drive (`xcvr_oe_n` stays 1).
- R9: `active_n` goes low for exactly one cycle, after the third rising edge, at the start of each matching read or write. An access in which the read and write conditions begin together gives one pulse.
- R10: `xcvr_to_bus` is 1 exactly while `xcvr_oe_n` is 0, and is 0 at all other times.
- R11: Each write cycle captures the data once. A change on the data-out lines while the write strobe is still held does not alter `led`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_master | input | 1 | 0 = slave mode (block responds), 1 = master mode (block idle) |
| bus_addr | input | 16 | Bus address lines |
| bus_dout | input | 8 | Bus data-out byte from the processor |
| st_out | input | 1 | Output-cycle status (sOUT), active high |
| st_inp | input | 1 | Input-cycle status (sINP), active high |
| wr_n | input | 1 | Write strobe, active low |
| dbin | input | 1 | Read strobe (pDBIN), active high |
| sw | input | 4 | Switch value returned in switch-read mode |
| bus_din | output | 8 | Byte driven toward the bus data-in lines, 00 when idle |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| xcvr_to_bus | output | 1 | Transceiver direction, 1 = logic toward bus |
| led | output | 8 | Latched byte for indicators |
| active_n | output | 1 | One-cycle activity pulse, active low |

## Verification
A write and a read of the port can start in the same cycle. The latch update and the read drive then coincide, and the activity flag sees two access edges at once. The bench raises both conditions on one clock edge and samples `bus_din` on the cycle before and the cycle after the latch edge. It expects the old byte, then the new byte. It also checks that `active_n` is low for one cycle only. A separate test changes the data-out byte while the write strobe is still held, to confirm that the latch captures only on the edge.

// File: rtl/s100_port_slave.sv
module s100_port_slave #(
  parameter logic [15:0] PORT_ADDR   = 16'h0068,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SW_W        = 4,
  parameter int          SYNC_STAGES = 2,
  parameter bit          READBACK    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_master,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_dout,
  input  logic              st_out,
  input  logic              st_inp,
  input  logic              wr_n,
  input  logic              dbin,
  input  logic [SW_W-1:0]   sw,
  output logic [DATA_W-1:0] bus_din,
  output logic              xcvr_oe_n,
  output logic              xcvr_to_bus,
  output logic [DATA_W-1:0] led,
  output logic              active_n
);

  localparam int VEC_W = ADDR_W + DATA_W + 5;
  localparam int REP   = DATA_W / SW_W;
  localparam logic [VEC_W-1:0] IDLE_VEC = VEC_W'(1) << 2;

  logic [VEC_W-1:0] raw_vec;
  logic [VEC_W-1:0] sync_q [SYNC_STAGES];
  logic [VEC_W-1:0] s_vec;

  assign raw_vec = {bus_addr, bus_dout, st_out, st_inp, wr_n, dbin, dir_master};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sync_q[g] <= IDLE_VEC;
        else if (g == 0) sync_q[g] <= raw_vec;
        else             sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign s_vec = sync_q[SYNC_STAGES-1];

  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic s_out, s_inp, s_wr_n, s_dbin, s_dir;

  assign {s_addr, s_data, s_out, s_inp, s_wr_n, s_dbin, s_dir} = s_vec;

  logic hit, wr_hit, rd_hit;
  logic wr_hit_q, rd_hit_q;
  logic wr_rise, rd_rise;

  assign hit     = (s_addr == PORT_ADDR) && !s_dir;
  assign wr_hit  = hit && s_out && !s_wr_n;
  assign rd_hit  = hit && s_inp && s_dbin;
  assign wr_rise = wr_hit && !wr_hit_q;
  assign rd_rise = rd_hit && !rd_hit_q;

  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hit_q <= 1'b0;
      rd_hit_q <= 1'b0;
      latch_q  <= '0;
      active_n <= 1'b1;
    end else begin
      wr_hit_q <= wr_hit;
      rd_hit_q <= rd_hit;
      if (wr_rise) latch_q <= s_data;
      active_n <= !(wr_rise || rd_rise);
    end
  end

  logic [DATA_W-1:0] rd_val;

  generate
    if (READBACK) begin : g_readback
      assign rd_val = latch_q;
    end else begin : g_switch
      assign rd_val = {REP{sw}};
    end
  endgenerate

  assign led         = latch_q;
  assign bus_din     = rd_hit ? rd_val : '0;
  assign xcvr_oe_n   = !rd_hit;
  assign xcvr_to_bus = rd_hit;

  p_din_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_oe_n |-> (bus_din == '0));

  p_dir_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_to_bus == !xcvr_oe_n);

  p_drive_needs_inp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_oe_n |-> ($past(st_inp, SYNC_STAGES) && $past(dbin, SYNC_STAGES)));

  p_master_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_dir |=> $stable(led));

  p_master_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_dir |-> xcvr_oe_n);

  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(led));

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_n) |-> ($past(wr_hit) || $past(rd_hit)));

endmodule

// File: tb/s100_port_slave_bench.sv
`timescale 1ns/1ps
module s100_port_slave_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        dir_master = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_dout = '0;
  logic        st_out = 1'b0, st_inp = 1'b0, wr_n = 1'b1, dbin = 1'b0;
  logic [3:0]  sw = 4'h9;

  logic [7:0] din_a, led_a, din_b, led_b;
  logic       oe_a, tb_a, act_a, oe_b, tb_b, act_b;

  s100_port_slave u_s100_port_slave (
    .clk(clk), .rst_n(rst_n), .dir_master(dir_master), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .st_out(st_out), .st_inp(st_inp), .wr_n(wr_n),
    .dbin(dbin), .sw(sw), .bus_din(din_a), .xcvr_oe_n(oe_a),
    .xcvr_to_bus(tb_a), .led(led_a), .active_n(act_a));

  s100_port_slave #(.READBACK(1'b0)) u_sw (
    .clk(clk), .rst_n(rst_n), .dir_master(dir_master), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .st_out(st_out), .st_inp(st_inp), .wr_n(wr_n),
    .dbin(dbin), .sw(sw), .bus_din(din_b), .xcvr_oe_n(oe_b),
    .xcvr_to_bus(tb_b), .led(led_b), .active_n(act_b));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_dout = d; st_out = 1'b1; wr_n = 1'b0;
    idle(4);
    st_out = 1'b0; wr_n = 1'b1;
    idle(3);
  endtask

  task automatic read_start(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; st_inp = 1'b1; dbin = 1'b1;
    idle(2);
  endtask

  task automatic read_end();
    st_inp = 1'b0; dbin = 1'b0;
    idle(3);
  endtask

  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h0068, 8'hA5, 8'hA5},
    {1'b1, 16'h0069, 8'h3C, 8'hA5},
    {1'b0, 16'h0068, 8'h00, 8'hA5},
    {1'b1, 16'h0168, 8'hFF, 8'hA5},
    {1'b1, 16'h8068, 8'h11, 8'hA5},
    {1'b1, 16'h0068, 8'h5A, 8'h5A},
    {1'b0, 16'h0068, 8'h00, 8'h5A},
    {1'b0, 16'h0060, 8'h00, 8'h00},
    {1'b1, 16'h0068, 8'h00, 8'h00},
    {1'b1, 16'h0068, 8'hFF, 8'hFF},
    {1'b0, 16'h0068, 8'h00, 8'hFF}
  };

  logic done = 1'b0;

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R4 led", {8'h0, led_a}, 16'h0000);
    chk("R4 oe_n", {15'h0, oe_a}, 16'h0001);
    chk("R4 to_bus", {15'h0, tb_a}, 16'h0000);
    chk("R4 din", {8'h0, din_a}, 16'h0000);
    chk("R4 active_n", {15'h0, act_a}, 16'h0001);
    rst_n = 1'b1;
    idle(3);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][32]) begin
        do_write(VEC[v][31:16], VEC[v][15:8]);
        chk(VEC[v][31:16] == 16'h0068 ? "R1 write" : "R2 foreign write",
            {8'h0, led_a}, {8'h0, VEC[v][7:0]});
      end else begin
        read_start(VEC[v][31:16]);
        chk("R5 readback", {8'h0, din_a}, {8'h0, VEC[v][7:0]});
        chk("R7 oe_n", {15'h0, oe_a}, {15'h0, VEC[v][31:16] != 16'h0068});
        chk("R10 to_bus", {15'h0, tb_a}, {15'h0, VEC[v][31:16] == 16'h0068});
        read_end();
        chk("R7 oe_n release", {15'h0, oe_a}, 16'h0001);
        chk("R7 din idle", {8'h0, din_a}, 16'h0000);
      end
    end

    // R3: strobe without status, status without strobe
    @(negedge clk);
    bus_addr = 16'h0068; bus_dout = 8'h42; wr_n = 1'b0; st_out = 1'b0;
    idle(5);
    chk("R3 strobe only", {8'h0, led_a}, 16'h00FF);
    wr_n = 1'b1; st_out = 1'b1;
    idle(5);
    chk("R3 status only", {8'h0, led_a}, 16'h00FF);
    st_out = 1'b0;
    idle(3);

    // R11: data changes while strobe held
    @(negedge clk);
    bus_addr = 16'h0068; bus_dout = 8'h12; st_out = 1'b1; wr_n = 1'b0;
    idle(3);
    chk("R9 write pulse", {15'h0, act_a}, 16'h0000);
    bus_dout = 8'h34;
    idle(1);
    chk("R9 pulse width", {15'h0, act_a}, 16'h0001);
    idle(4);
    chk("R11 single capture", {8'h0, led_a}, 16'h0012);
    st_out = 1'b0; wr_n = 1'b1;
    idle(3);

    // R6: switch mode instance
    sw = 4'h9;
    read_start(16'h0068);
    chk("R6 switch read", {8'h0, din_b}, 16'h0099);
    chk("R5 readback alongside", {8'h0, din_a}, 16'h0012);
    read_end();
    sw = 4'h6;
    read_start(16'h0068);
    chk("R6 switch read 2", {8'h0, din_b}, 16'h0066);
    read_end();

    // R8: master mode
    dir_master = 1'b1;
    do_write(16'h0068, 8'h77);
    chk("R8 no write", {8'h0, led_a}, 16'h0012);
    read_start(16'h0068);
    chk("R8 no drive", {15'h0, oe_a}, 16'h0001);
    chk("R8 din idle", {8'h0, din_a}, 16'h0000);
    read_end();
    dir_master = 1'b0;
    idle(3);

    // concurrent write and read start
    @(negedge clk);
    bus_addr = 16'h0068; bus_dout = 8'hC3;
    st_out = 1'b1; wr_n = 1'b0; st_inp = 1'b1; dbin = 1'b1;
    idle(2);
    chk("R5 old byte before latch", {8'h0, din_a}, 16'h0012);
    chk("R9 no early pulse", {15'h0, act_a}, 16'h0001);
    idle(1);
    chk("R5 new byte after latch", {8'h0, din_a}, 16'h00C3);
    chk("R1 concurrent write", {8'h0, led_a}, 16'h00C3);
    chk("R9 joint pulse", {15'h0, act_a}, 16'h0000);
    idle(1);
    chk("R9 single pulse", {15'h0, act_a}, 16'h0001);
    st_out = 1'b0; wr_n = 1'b1; st_inp = 1'b0; dbin = 1'b0;
    idle(2);
    chk("R7 end of read", {15'h0, oe_a}, 16'h0001);
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule